// File: doc/BRIEF.md
# Complex Symmetric FIR Channel Filter

This block is a single-rate, linear-phase FIR filter for complex samples with 16-bit signed real and imaginary parts. It is meant as the last channel-shaping stage of a receive chain. One output comes out for every accepted input. The real and imaginary parts are filtered separately with the same real coefficients. Because the impulse response is symmetric, only the first half of the coefficient set is held. For an odd length, that half includes the middle coefficient.

For each output, the filter adds the two samples that sit at mirrored positions in the delay line and multiplies the sum by their shared coefficient. For an odd length, the middle sample is multiplied alone. All products are summed in an accumulator that cannot overflow. The sum is then shifted right by a run-time amount. The shift rounds toward minus infinity and the result wraps to 16 bits with no saturation. Coefficients are typically in Q1.15 format, so a shift of 15 gives unity gain.

Samples arrive and leave on ready/valid streams. Coefficients are written one per strobe through a small load port while the output stage is empty.

Top module: `chan_fir_sym`

## Requirements
- R1: After reset, `out_valid_o` is 0, `out_re_o` and `out_im_o` are 0, and `in_ready_o` is 1 when `coef_we_i` is 0 and `out_ready_i` is 1. All stored coefficients are 0 and the load pointer is at address 0.
- R2: `in_ready_o` = (!`out_valid_o` | `out_ready_i`) & !`coef_we_i`. An input is accepted when it is valid in a cycle where `in_ready_o` is high. The result for that input appears with `out_valid_o` high in the next cycle. If no new input is accepted, `out_valid_o` drops in the cycle after it was consumed.
- R3: Let x[0] be the newest sample and x[j] the sample accepted j inputs earlier. The output is y = sum over j of h[j]·x[j], for j from 0 to N-1. Here h[j] = c[min(j, N-1-j)], where c[k] is stored coefficient k. The real and imaginary parts each use this sum.
- R4: For an odd length N, (N+1)/2 coefficients are stored and c[(N-1)/2] multiplies the middle sample once. For an even length, N/2 coefficients are stored and each one multiplies a pair of samples.
- R5: Until N-1 samples have been accepted after reset, every history position not yet filled counts as zero.
- R6: Each cycle in which `coef_we_i` is high and the output is empty writes `coef_i` to the address held by the load pointer. The pointer then advances by one. Address 0 is the outermost tap, the one that weights the newest and the oldest sample. After the last stored address, the pointer wraps to 0.
- R7: A coefficient strobe while `out_valid_o` is high writes nothing and does not move the load pointer. No sample is accepted in any cycle where `coef_we_i` is high.
- R8: While `out_valid_o` is high and `out_ready_i` is low, the output data stays stable and `in_ready_o` is low.
- R9: Each output part equals the low 16 bits of floor(y / 2^`shift_i`), using the `shift_i` value of the accepting cycle. Results outside the 16-bit range wrap and do not saturate.
- R10: The accumulator holds the exact sum for any input and coefficient values, including full-scale negative ones.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| in_valid_i | input | 1 | Input sample valid |
| in_ready_o | output | 1 | Filter can accept a sample |
| in_re_i | input | DW | Input real part, signed |
| in_im_i | input | DW | Input imaginary part, signed |
| shift_i | input | SHIFT_W | Right-shift amount applied to the accepted sample's result |
| out_valid_o | output | 1 | Output sample valid |
| out_ready_i | input | 1 | Downstream accepts the output |
| out_re_o | output | DW | Output real part, signed |
| out_im_o | output | DW | Output imaginary part, signed |
| coef_we_i | input | 1 | Coefficient write strobe |
| coef_i | input | CW | Coefficient value, signed |

## Verification
The assertions assume that `out_ready_i` and the sample inputs are known after reset. The overflow check also assumes the two's-complement ranges of the input and coefficient widths, so the accumulator bound depends only on the tap count. The stimulus keeps to these assumptions because every input is driven from a defined value right after reset. Coefficient strobes are issued both when the output is empty and when it is stalled, so the ignored-write case is exercised. Full-scale negative samples with full-scale negative coefficients push the accumulator to its worst-case magnitude. A second instance with an even length runs in parallel with the same stimulus, so both the paired-only and the centre-tap forms are covered.

// File: rtl/cfir_pkg.sv
package cfir_pkg;
  function automatic int half_len(input int n);
    return (n + 1) / 2;
  endfunction

  // pre-add adds one bit, product DW+CW, then the tree of half_len terms
  function automatic int acc_width(input int dw, input int cw, input int n);
    return dw + cw + 2 + $clog2(half_len(n));
  endfunction
endpackage

// File: rtl/cfir_coef_store.sv
module cfir_coef_store #(
  parameter int NHALF = 4,
  parameter int CW    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 we_i,
  input  logic signed [CW-1:0] data_i,
  output logic signed [CW-1:0] coef_o [NHALF]
);
  localparam int PTR_W = (NHALF > 1) ? $clog2(NHALF) : 1;
  localparam logic [PTR_W-1:0] LAST = PTR_W'(NHALF - 1);

  logic [PTR_W-1:0] ptr_q;
  logic signed [CW-1:0] coef_q [NHALF];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ptr_q <= '0;
    end else if (we_i) begin
      ptr_q <= (ptr_q == LAST) ? '0 : ptr_q + 1'b1;
    end
  end

  for (genvar k = 0; k < NHALF; k++) begin : g_coef
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) coef_q[k] <= '0;
      else if (we_i && ptr_q == PTR_W'(k)) coef_q[k] <= data_i;
    end
    assign coef_o[k] = coef_q[k];
  end

  AST_PTR_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !we_i |=> $stable(ptr_q)) else $error("pointer moved without strobe"); // R6
  AST_PTR_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ptr_q <= LAST) else $error("pointer out of range"); // R6
endmodule

// File: rtl/cfir_hist.sv
module cfir_hist #(
  parameter int DEPTH = 6,
  parameter int DW    = 16
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 en_i,
  input  logic signed [DW-1:0] din_i,
  output logic signed [DW-1:0] hist_o [DEPTH]
);
  logic signed [DW-1:0] hist_q [DEPTH];

  for (genvar i = 0; i < DEPTH; i++) begin : g_stage
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) hist_q[i] <= '0;
      else if (en_i) hist_q[i] <= (i == 0) ? din_i : hist_q[(i == 0) ? 0 : i - 1];
    end
    assign hist_o[i] = hist_q[i];
  end

  AST_HIST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !en_i |=> $stable(hist_q[0])) else $error("history moved while idle"); // R2
endmodule

// File: rtl/cfir_lane.sv
module cfir_lane #(
  parameter int NUM_TAPS = 7,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int SHIFT_W  = 6,
  parameter int ACC_W    = 36
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic signed [DW-1:0] win_i  [NUM_TAPS],
  input  logic signed [CW-1:0] coef_i [(NUM_TAPS+1)/2],
  input  logic [SHIFT_W-1:0]   shift_i,
  output logic signed [DW-1:0] y_o
);
  localparam int NPAIR = NUM_TAPS / 2;
  localparam int ODD   = NUM_TAPS % 2;
  localparam int NHALF = NPAIR + ODD;
  localparam int PW    = DW + CW + 1;
  localparam logic signed [ACC_W-1:0] ACC_BOUND = ACC_W'(NUM_TAPS) <<< (DW + CW - 2);

  logic signed [PW-1:0]    prod [NHALF];
  logic signed [ACC_W-1:0] acc;

  for (genvar k = 0; k < NPAIR; k++) begin : g_pair
    logic signed [DW:0] pre;
    assign pre     = (DW+1)'(win_i[k]) + (DW+1)'(win_i[NUM_TAPS-1-k]);
    assign prod[k] = PW'(pre) * PW'(coef_i[k]);
  end

  if (ODD != 0) begin : g_centre
    assign prod[NPAIR] = PW'(win_i[NPAIR]) * PW'(coef_i[NPAIR]);
  end

  always_comb begin
    acc = '0;
    for (int k = 0; k < NHALF; k++) acc = acc + ACC_W'(prod[k]);
  end

  // arithmetic shift floors; truncation wraps
  assign y_o = DW'(acc >>> shift_i);

  AST_NO_OVERFLOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (acc <= ACC_BOUND) && (acc >= -ACC_BOUND)) else $error("accumulator out of bound"); // R10
endmodule

// File: rtl/chan_fir_sym.sv
module chan_fir_sym
  import cfir_pkg::*;
#(
  parameter int NUM_TAPS = 7,
  parameter int DW       = 16,
  parameter int CW       = 16,
  parameter int SHIFT_W  = 6
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 in_valid_i,
  output logic                 in_ready_o,
  input  logic signed [DW-1:0] in_re_i,
  input  logic signed [DW-1:0] in_im_i,
  input  logic [SHIFT_W-1:0]   shift_i,
  output logic                 out_valid_o,
  input  logic                 out_ready_i,
  output logic signed [DW-1:0] out_re_o,
  output logic signed [DW-1:0] out_im_o,
  input  logic                 coef_we_i,
  input  logic signed [CW-1:0] coef_i
);
  localparam int NHALF = half_len(NUM_TAPS);
  localparam int ACC_W = acc_width(DW, CW, NUM_TAPS);
  localparam int HDEPTH = NUM_TAPS - 1;

  logic                 accept;
  logic                 coef_wr;
  logic                 out_vld_q;
  logic signed [DW-1:0] out_re_q, out_im_q;
  logic signed [DW-1:0] din  [2];
  logic signed [DW-1:0] yv   [2];
  logic signed [CW-1:0] coef [NHALF];

  assign in_ready_o = (!out_vld_q || out_ready_i) && !coef_we_i;
  assign accept     = in_valid_i && in_ready_o;
  assign coef_wr    = coef_we_i && !out_vld_q;
  assign din[0]     = in_re_i;
  assign din[1]     = in_im_i;

  cfir_coef_store #(.NHALF(NHALF), .CW(CW)) u_coef (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .we_i   (coef_wr),
    .data_i (coef_i),
    .coef_o (coef)
  );

  for (genvar c = 0; c < 2; c++) begin : g_comp
    logic signed [DW-1:0] hist [HDEPTH];
    logic signed [DW-1:0] win  [NUM_TAPS];

    cfir_hist #(.DEPTH(HDEPTH), .DW(DW)) u_hist (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .en_i   (accept),
      .din_i  (din[c]),
      .hist_o (hist)
    );

    assign win[0] = din[c];
    for (genvar i = 1; i < NUM_TAPS; i++) begin : g_win
      assign win[i] = hist[i-1];
    end

    cfir_lane #(
      .NUM_TAPS(NUM_TAPS), .DW(DW), .CW(CW), .SHIFT_W(SHIFT_W), .ACC_W(ACC_W)
    ) u_lane (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .win_i   (win),
      .coef_i  (coef),
      .shift_i (shift_i),
      .y_o     (yv[c])
    );
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_vld_q <= 1'b0;
      out_re_q  <= '0;
      out_im_q  <= '0;
    end else if (accept) begin
      out_vld_q <= 1'b1;
      out_re_q  <= yv[0];
      out_im_q  <= yv[1];
    end else if (out_ready_i) begin
      out_vld_q <= 1'b0;
    end
  end

  assign out_valid_o = out_vld_q;
  assign out_re_o    = out_re_q;
  assign out_im_o    = out_im_q;

  AST_OUT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |=> (out_valid_o && $stable(out_re_o) && $stable(out_im_o)))
    else $error("output changed under stall"); // R8
  AST_STALL_NO_READY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && !out_ready_i) |-> !in_ready_o) else $error("ready under stall"); // R8
  AST_VALID_AFTER_ACCEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (in_valid_i && in_ready_o) |=> out_valid_o) else $error("missing output"); // R2
  AST_DRAIN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid_o && out_ready_i && !(in_valid_i && in_ready_o)) |=> !out_valid_o)
    else $error("output not drained"); // R2
endmodule

// File: tb/sim_chan_fir_sym.sv
`timescale 1ns/1ps
module sim_chan_fir_sym;
  localparam int N0 = 7;
  localparam int N1 = 6;  // even length instance, R4
  localparam int DW = 16;
  localparam int SW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic in_valid = 1'b0, out_ready = 1'b1, coef_we = 1'b0;
  logic signed [DW-1:0] in_re = '0, in_im = '0, coef_d = '0;
  logic [SW-1:0] shift = '0;
  logic in_ready [2];
  logic out_valid [2];
  logic signed [DW-1:0] out_re [2];
  logic signed [DW-1:0] out_im [2];

  int n_chk = 0, n_fail = 0;
  string req_tag = "R1";
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  chan_fir_sym #(.NUM_TAPS(N0), .DW(DW), .CW(DW), .SHIFT_W(SW)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready[0]),
    .in_re_i(in_re), .in_im_i(in_im), .shift_i(shift), .out_valid_o(out_valid[0]),
    .out_ready_i(out_ready), .out_re_o(out_re[0]), .out_im_o(out_im[0]),
    .coef_we_i(coef_we), .coef_i(coef_d));

  chan_fir_sym #(.NUM_TAPS(N1), .DW(DW), .CW(DW), .SHIFT_W(SW)) u1 (
    .clk_i(clk), .rst_ni(rst_n), .in_valid_i(in_valid), .in_ready_o(in_ready[1]),
    .in_re_i(in_re), .in_im_i(in_im), .shift_i(shift), .out_valid_o(out_valid[1]),
    .out_ready_i(out_ready), .out_re_o(out_re[1]), .out_im_o(out_im[1]),
    .coef_we_i(coef_we), .coef_i(coef_d));

  // behavioural reference
  int  hr [2][8];
  int  hi [2][8];
  int  cm [2][4];
  int  ptr [2];
  bit  ev;
  int  er [2];
  int  ei [2];

  function automatic int taps(input int d);
    return (d == 0) ? N0 : N1;
  endfunction

  function automatic int wrap16(input longint v);
    return int'(shortint'(v));
  endfunction

  function automatic longint fir(input int d, input bit im);
    longint s = 0;
    for (int j = 0; j < taps(d); j++) begin
      int k = (j < taps(d) - 1 - j) ? j : taps(d) - 1 - j;
      s += longint'(cm[d][k]) * longint'(im ? hi[d][j] : hr[d][j]);
    end
    return s;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      ev = 1'b0;
      for (int d = 0; d < 2; d++) begin
        ptr[d] = 0; er[d] = 0; ei[d] = 0;
        for (int j = 0; j < 8; j++) begin hr[d][j] = 0; hi[d][j] = 0; end
        for (int k = 0; k < 4; k++) cm[d][k] = 0;
      end
    end else begin
      bit acc;
      acc = in_valid && (!ev || out_ready) && !coef_we;
      if (coef_we && !ev)
        for (int d = 0; d < 2; d++) begin
          cm[d][ptr[d]] = int'(coef_d);
          ptr[d] = (ptr[d] + 1) % ((taps(d) + 1) / 2);
        end
      if (acc) begin
        for (int d = 0; d < 2; d++) begin
          for (int j = 7; j > 0; j--) begin hr[d][j] = hr[d][j-1]; hi[d][j] = hi[d][j-1]; end
          hr[d][0] = int'(in_re); hi[d][0] = int'(in_im);
          er[d] = wrap16(fir(d, 1'b0) >>> shift);
          ei[d] = wrap16(fir(d, 1'b1) >>> shift);
        end
        ev = 1'b1;
      end else if (out_ready) begin
        ev = 1'b0;
      end
    end
  end

  task automatic chk(input bit ok, input string what, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req_tag, what, act, exp);
    end
  endtask

  // per-cycle comparison on the falling edge
  always @(negedge clk) begin
    if (rst_n && !done) begin
      for (int d = 0; d < 2; d++) begin
        bit rdy_exp;
        rdy_exp = (!ev || out_ready) && !coef_we;
        chk(in_ready[d] == rdy_exp, $sformatf("R2 in_ready u%0d", d), in_ready[d], rdy_exp);
        chk(out_valid[d] == ev, $sformatf("R2 out_valid u%0d", d), out_valid[d], ev);
        if (ev) begin
          chk(int'(out_re[d]) == er[d], $sformatf("R3 re u%0d", d), out_re[d], er[d]);
          chk(int'(out_im[d]) == ei[d], $sformatf("R3 im u%0d", d), out_im[d], ei[d]);
        end
      end
    end
  end

  task automatic drive(input bit v, input int re, input int im, input int sh,
                       input bit rdy, input bit we, input int cd);
    @(negedge clk);
    #1;
    in_valid = v; in_re = DW'(re); in_im = DW'(im); shift = SW'(sh);
    out_ready = rdy; coef_we = we; coef_d = DW'(cd);
  endtask

  task automatic load(input int v);
    drive(1'b0, 0, 0, 0, 1'b1, 1'b1, v);
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) drive(1'b0, 0, 0, 0, 1'b1, 1'b0, 0);
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    #(5.0 * 150000);
    req_tag = "watchdog";
    chk(1'b0, "timeout", 0, 1);
    finish_run();
  end

  initial begin
    repeat (5) @(posedge clk);
    @(negedge clk); #1 rst_n = 1'b1;
    @(negedge clk);
    req_tag = "R1";
    for (int d = 0; d < 2; d++) begin
      chk(out_valid[d] == 1'b0, "R1 out_valid after reset", out_valid[d], 0);
      chk(out_re[d] == 0 && out_im[d] == 0, "R1 data after reset", out_re[d], 0);
      chk(in_ready[d] == 1'b1, "R1 ready after reset", in_ready[d], 1);
    end

    // R1: coefficients zero, so first outputs are zero
    drive(1'b1, 12000, -5000, 0, 1'b1, 1'b0, 0);
    idle(2);
    for (int d = 0; d < 2; d++) begin
      chk(out_re[d] == 0, "R1 zero coefficients", out_re[d], 0);
    end

    // R6: ordered load from the outermost tap
    req_tag = "R6";
    load(-1200); load(3000); load(-9000); load(28004);
    idle(1);

    // R5: history after reset holds the one earlier sample and zeros
    req_tag = "R5";
    for (int i = 0; i < 8; i++) drive(1'b1, 1000 * (i + 1), -700 * i, 15, 1'b1, 1'b0, 0);
    idle(2);

    // R3, R9: random stream with random shift
    req_tag = "R3";
    for (int i = 0; i < 300; i++)
      drive($urandom_range(0, 3) != 0, $urandom_range(0, 65535) - 32768,
            $urandom_range(0, 65535) - 32768, $urandom_range(0, 30), 1'b1, 1'b0, 0);
    idle(2);

    // R8: random backpressure
    req_tag = "R8";
    for (int i = 0; i < 300; i++)
      drive($urandom_range(0, 1), $urandom_range(0, 65535) - 32768,
            $urandom_range(0, 65535) - 32768, $urandom_range(10, 20),
            $urandom_range(0, 1), 1'b0, 0);
    idle(2);

    // R7: strobes during a stalled output are ignored
    req_tag = "R7";
    drive(1'b1, 3000, 2000, 15, 1'b0, 1'b0, 0);
    drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 32767);
    drive(1'b0, 0, 0, 0, 1'b0, 1'b1, 32767);
    drive(1'b1, 500, 500, 15, 1'b0, 1'b1, 32767);
    for (int i = 0; i < 12; i++) drive(1'b1, 4000 - 700 * i, 900 * i, 15, 1'b1, 1'b0, 0);
    idle(2);

    // R9, R10: full-scale negative data and coefficients
    req_tag = "R10";
    load(-32768); load(-32768); load(-32768); load(-32768);
    idle(1);
    for (int i = 0; i < 10; i++) drive(1'b1, -32768, -32768, 0, 1'b1, 1'b0, 0);
    req_tag = "R9";
    for (int i = 0; i < 10; i++) drive(1'b1, -32768, 32767, 15, 1'b1, 1'b0, 0);
    for (int i = 0; i < 10; i++) drive(1'b1, -32768, -32768, 3, 1'b1, 1'b0, 0);
    idle(2);

    // R6, R4: five writes, pointer wraps, impulse shows the layout
    req_tag = "R6 wrap";
    load(100); load(-200); load(300); load(-400); load(500);
    idle(1);
    req_tag = "R4";
    drive(1'b1, 16384, -16384, 14, 1'b1, 1'b0, 0);
    for (int i = 0; i < 9; i++) drive(1'b1, 0, 0, 14, 1'b1, 1'b0, 0);
    idle(3);

    finish_run();
  end
endmodule